// File: doc/BRIEF.md
# Serial Poll Status Responder

This block keeps an instrument's status byte and answers a bus controller's serial poll on its own, so the host processor need not take part in each poll. The host writes the status byte; setting bit 6 in that write raises a service request. The request drives the service-request line until a serial poll has reported it. The poll then returns the status byte with bit 6 showing the request, and the request clears.

The bus handshake is reduced to a simple level/pulse pair. The bus side holds `byte_req` high while it wants a status byte. The block answers with a single-cycle `byte_ack` and the byte on `byte_out`. Two pulses, `poll_enter` and `poll_exit`, open and close the serial-poll window. A request outside that window is never answered. In hold mode (`hold_poll` high), a request is not answered from the stored byte. The block instead raises `poll_irq` and waits for the host to write a fresh status byte, then answers with that byte.

Top module: `spr_responder`

## Requirements
- R1: After reset, `srq`, `byte_ack` and `poll_irq` are 0 and the stored status byte is 0.
- R2: A host write with `host_wdata[6]`=1 sets the service request, and `srq` is 1 from the cycle after the write.
- R3: With `hold_poll`=0 and the poll window open, a `byte_req` seen at a clock edge gives `byte_ack`=1 in the following cycle, for exactly one cycle.
- R4: The answered byte carries bits 7 and 5..0 as last written by the host, and bit 6 equals the service-request state at the moment of answering. Bit 4 is the message-available flag and bits 3..0 are device-specific; both pass through unchanged.
- R5: Once an answered byte has bit 6 = 1, `srq` is 0 in the cycle after the acknowledge, and a later poll returns bit 6 = 0.
- R6: While the poll window is closed (before `poll_enter`, or after `poll_exit`), `byte_req` produces no `byte_ack` and leaves `srq` unchanged.
- R7: A host write with `host_wdata[6]`=0 updates the other status bits but does not clear a pending service request.
- R8: One `byte_req` high period produces exactly one `byte_ack`, however long the request is held.
- R9: With `hold_poll`=1, a request raises `poll_irq` and no `byte_ack` is given until a host write. The write is answered in the next cycle with the written byte, bit 6 being 1 if a request was pending or set by that write. `poll_irq` then drops.
- R10: `poll_exit` during a held poll drops `poll_irq` and abandons the poll without an acknowledge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host status write strobe |
| host_wdata | input | 8 | Status byte; bit 6 = 1 requests service |
| hold_poll | input | 1 | 1: delay each poll until a fresh host write |
| poll_enter | input | 1 | Pulse: open serial-poll window |
| poll_exit | input | 1 | Pulse: close serial-poll window |
| byte_req | input | 1 | Bus side wants the status byte (level) |
| byte_ack | output | 1 | One-cycle pulse: `byte_out` is valid |
| byte_out | output | 8 | Status byte returned to the controller |
| srq | output | 1 | Service-request line |
| poll_irq | output | 1 | Host interrupt: held poll awaiting a write |

## Verification
The assertions assume that `poll_enter` and `poll_exit` are never pulsed in the same cycle. They also assume that the bus side keeps `byte_req` high until it sees `byte_ack` and then lowers it before asking again. The bench keeps to this: its poll task raises the request, waits for the acknowledge, and drops the request one cycle later. Host writes during a held poll come only after the interrupt has been observed. All inputs change on the falling clock edge, so nothing races the registering edge.

// File: rtl/spr_pkg.sv
package spr_pkg;
    localparam int STB_W   = 8;
    localparam int RSV_POS = 6;

    typedef enum logic [1:0] {
        PS_IDLE = 2'd0,
        PS_WAIT = 2'd1,
        PS_DONE = 2'd2
    } poll_st_e;

    typedef struct packed {
        logic [STB_W-2:0] bits;
        logic             rsv;
    } stb_reg_t;

    typedef struct packed {
        poll_st_e         st;
        logic             open;
        logic             ack;
        logic [STB_W-1:0] data;
    } poll_reg_t;
endpackage

// File: rtl/spr_status_reg.sv
module spr_status_reg
    import spr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [STB_W-1:0] wdata,
    input  logic             clr_old,
    input  logic             clr_all,
    output logic [STB_W-1:0] cur_byte
);
    stb_reg_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (wr)
            r_d.bits = {wdata[STB_W-1:RSV_POS+1], wdata[RSV_POS-1:0]};
        if (clr_all)
            r_d.rsv = 1'b0;
        else
            r_d.rsv = (r_q.rsv & ~clr_old) | (wr & wdata[RSV_POS]);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign cur_byte = {r_q.bits[STB_W-2:RSV_POS], r_q.rsv, r_q.bits[RSV_POS-1:0]};

    // R2
    rsv_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && wdata[RSV_POS] && !clr_all) |=> cur_byte[RSV_POS]);

    // R5
    rsv_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cur_byte[RSV_POS]) |-> $past(clr_old || clr_all));

    // R7
    rsv_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_byte[RSV_POS] && !clr_old && !clr_all) |=> cur_byte[RSV_POS]);
endmodule

// File: rtl/spr_poll_fsm.sv
module spr_poll_fsm
    import spr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hold_poll,
    input  logic             poll_enter,
    input  logic             poll_exit,
    input  logic             byte_req,
    input  logic             host_wr,
    input  logic [STB_W-1:0] host_wdata,
    input  logic [STB_W-1:0] cur_byte,
    output logic             clr_old,
    output logic             clr_all,
    output logic             ack,
    output logic [STB_W-1:0] data,
    output logic             irq
);
    poll_reg_t        p_d, p_q;
    logic [STB_W-1:0] fresh;

    always_comb begin
        fresh          = host_wdata;
        fresh[RSV_POS] = host_wdata[RSV_POS] | cur_byte[RSV_POS];
    end

    always_comb begin
        p_d     = p_q;
        p_d.ack = 1'b0;
        clr_old = 1'b0;
        clr_all = 1'b0;
        if (poll_exit)       p_d.open = 1'b0;
        else if (poll_enter) p_d.open = 1'b1;

        unique case (p_q.st)
            PS_IDLE: begin
                if (p_q.open && !poll_exit && byte_req) begin
                    if (hold_poll) begin
                        p_d.st = PS_WAIT;
                    end else begin
                        p_d.ack  = 1'b1;
                        p_d.data = cur_byte;
                        clr_old  = cur_byte[RSV_POS];
                        p_d.st   = PS_DONE;
                    end
                end
            end
            PS_WAIT: begin
                if (!p_q.open || poll_exit || !byte_req) begin
                    p_d.st = PS_IDLE;
                end else if (host_wr) begin
                    p_d.ack  = 1'b1;
                    p_d.data = fresh;
                    clr_all  = fresh[RSV_POS];
                    p_d.st   = PS_DONE;
                end
            end
            PS_DONE: begin
                if (!byte_req) p_d.st = PS_IDLE;
            end
            default: p_d.st = PS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) p_q <= '{st: PS_IDLE, open: 1'b0, ack: 1'b0, data: '0};
        else        p_q <= p_d;
    end

    assign ack  = p_q.ack;
    assign data = p_q.data;
    assign irq  = (p_q.st == PS_WAIT);

    // R3
    ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !ack);

    // R6
    ack_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ack) |-> $past(byte_req) && $past(p_q.open));

    // R9
    hold_noack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !host_wr) |=> !ack);

    // R10
    exit_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        poll_exit |=> !irq && !ack);
endmodule

// File: rtl/spr_responder.sv
module spr_responder
    import spr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       host_wr,
    input  logic [7:0] host_wdata,
    input  logic       hold_poll,
    input  logic       poll_enter,
    input  logic       poll_exit,
    input  logic       byte_req,
    output logic       byte_ack,
    output logic [7:0] byte_out,
    output logic       srq,
    output logic       poll_irq
);
    logic [STB_W-1:0] cur_byte;
    logic             clr_old, clr_all;

    spr_status_reg u_stb (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (host_wr),
        .wdata    (host_wdata),
        .clr_old  (clr_old),
        .clr_all  (clr_all),
        .cur_byte (cur_byte)
    );

    spr_poll_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .hold_poll  (hold_poll),
        .poll_enter (poll_enter),
        .poll_exit  (poll_exit),
        .byte_req   (byte_req),
        .host_wr    (host_wr),
        .host_wdata (host_wdata),
        .cur_byte   (cur_byte),
        .clr_old    (clr_old),
        .clr_all    (clr_all),
        .ack        (byte_ack),
        .data       (byte_out),
        .irq        (poll_irq)
    );

    assign srq = cur_byte[RSV_POS];

    // R5
    srq_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_ack && byte_out[RSV_POS] && !host_wr) |-> !srq);
endmodule

// File: tb/spr_responder_test.sv
module spr_responder_test;
    localparam int CLK_PERIOD = 10;
    localparam int WD_LIMIT   = 5000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_wr = 1'b0;
    logic [7:0] host_wdata = '0;
    logic       hold_poll = 1'b0;
    logic       poll_enter = 1'b0;
    logic       poll_exit = 1'b0;
    logic       byte_req = 1'b0;
    logic       byte_ack;
    logic [7:0] byte_out;
    logic       srq;
    logic       poll_irq;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    spr_responder uut (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_wdata(host_wdata),
        .hold_poll(hold_poll), .poll_enter(poll_enter), .poll_exit(poll_exit),
        .byte_req(byte_req), .byte_ack(byte_ack), .byte_out(byte_out),
        .srq(srq), .poll_irq(poll_irq)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > WD_LIMIT) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected <%0d cycles", cyc, WD_LIMIT);
            finish_run();
        end
    end

    task automatic host_write(input logic [7:0] d);
        @(negedge clk); host_wr = 1'b1; host_wdata = d;
        @(negedge clk); host_wr = 1'b0;
    endtask

    task automatic pulse_enter();
        @(negedge clk); poll_enter = 1'b1;
        @(negedge clk); poll_enter = 1'b0;
    endtask

    task automatic pulse_exit();
        @(negedge clk); poll_exit = 1'b1;
        @(negedge clk); poll_exit = 1'b0;
    endtask

    // immediate-mode poll: ack expected exactly one cycle after request
    task automatic poll_imm(input string req, input logic [7:0] exp);
        @(negedge clk); byte_req = 1'b1;
        @(negedge clk);
        check({req, " ack latency"}, {7'd0, byte_ack}, 8'h01);
        check({req, " byte"}, byte_out, exp);
        byte_req = 1'b0;
        @(negedge clk);
        check({req, " ack single"}, {7'd0, byte_ack}, 8'h00);
    endtask

    task automatic t_reset();
        check("R1 srq", {7'd0, srq}, 8'h00);
        check("R1 ack", {7'd0, byte_ack}, 8'h00);
        check("R1 irq", {7'd0, poll_irq}, 8'h00);
        pulse_enter();
        poll_imm("R1 stored byte", 8'h00);
        pulse_exit();
    endtask

    task automatic t_closed_window();
        int acks = 0;
        host_write(8'h45);
        check("R2 srq set", {7'd0, srq}, 8'h01);
        @(negedge clk); byte_req = 1'b1;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            if (byte_ack) acks++;
        end
        byte_req = 1'b0;
        check("R6 no ack closed", acks[7:0], 8'h00);
        check("R6 srq unchanged", {7'd0, srq}, 8'h01);
    endtask

    task automatic t_auto_poll();
        pulse_enter();
        poll_imm("R3 R4 first poll", 8'h45);
        check("R5 srq cleared", {7'd0, srq}, 8'h00);
        poll_imm("R5 second poll", 8'h05);
    endtask

    task automatic t_pending_keep();
        host_write(8'h40);
        host_write(8'h13);
        check("R7 srq kept", {7'd0, srq}, 8'h01);
        poll_imm("R7 R4 merged byte", 8'h53);
        check("R5 srq after", {7'd0, srq}, 8'h00);
    endtask

    task automatic t_long_req();
        int acks = 0;
        host_write(8'hA9);
        @(negedge clk); byte_req = 1'b1;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            if (byte_ack) begin
                acks++;
                check("R8 byte", byte_out, 8'hA9);
            end
        end
        byte_req = 1'b0;
        @(negedge clk);
        check("R8 one ack", acks[7:0], 8'h01);
    endtask

    task automatic t_hold();
        hold_poll = 1'b1;
        host_write(8'h40);
        @(negedge clk); byte_req = 1'b1;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check("R9 no ack while held", {7'd0, byte_ack}, 8'h00);
        end
        check("R9 irq", {7'd0, poll_irq}, 8'h01);
        host_wr = 1'b1; host_wdata = 8'h82;
        @(negedge clk);
        host_wr = 1'b0;
        check("R9 ack after write", {7'd0, byte_ack}, 8'h01);
        check("R9 fresh byte", byte_out, 8'hC2);
        check("R9 irq drop", {7'd0, poll_irq}, 8'h00);
        check("R9 srq cleared", {7'd0, srq}, 8'h00);
        byte_req = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_exit_abort();
        @(negedge clk); byte_req = 1'b1;
        @(negedge clk); @(negedge clk);
        check("R10 irq up", {7'd0, poll_irq}, 8'h01);
        poll_exit = 1'b1;
        @(negedge clk); poll_exit = 1'b0;
        check("R10 irq dropped", {7'd0, poll_irq}, 8'h00);
        check("R10 no ack", {7'd0, byte_ack}, 8'h00);
        host_write(8'h11);
        check("R10 no ack after write", {7'd0, byte_ack}, 8'h00);
        byte_req = 1'b0;
        hold_poll = 1'b0;
        @(negedge clk); byte_req = 1'b1;
        @(negedge clk); @(negedge clk);
        check("R6 closed after exit", {7'd0, byte_ack}, 8'h00);
        byte_req = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_closed_window();
        t_auto_poll();
        t_pending_keep();
        t_long_req();
        t_hold();
        t_exit_abort();
        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule